// File: doc/BRIEF.md
# SCSI Command and Message Collector

This block sits on the target side of a parallel SCSI bus. It watches each byte handed over by the initiator while the bus is in the command phase or the message-out phase. From those bytes it rebuilds the command descriptor and tracks where each message ends. As soon as the last descriptor byte arrives, it reports how many bytes the coming data phase carries and in which direction they move.

The descriptor length comes from the top three opcode bits. Message boundaries are found byte by byte. That includes extended messages, whose length is known only once their second byte is in. An identify message leaves a logical unit number pending. That number is written into bits 7:5 of descriptor byte 1 when the next command completes. A table of per-opcode rules then gives the transfer length in bytes and a 2-bit direction code. Executing the command and moving the data belong to other blocks.

The transfer length output is 25 bits wide by default. That is the smallest width that holds 65535 blocks of 512 bytes.

Top module: `scsi_collect`

## Requirements
- R1: A byte is taken only in a cycle where `byteValid` is high and `phase` is 3'b010 (command) or 3'b110 (message-out). Strobes in any other phase produce no done pulse and leave every output unchanged.
- R2: The descriptor length follows opcode bits 7:5: group 0 and 7 give 6 bytes, groups 1, 2 and 6 give 10, groups 3 and 5 give 12, and group 4 gives 16. `cmdDone` is high for exactly the one cycle after the clock edge that takes the final byte. `cmdLen` gives the length. Byte i sits at `cmdBytes[8*i+7:8*i]`, and bytes at or beyond the length read as zero.
- R3: A message whose first byte is 0x00, in the range 0x02 to 0x1F, or 0x80 or above is one byte long. A first byte from 0x20 to 0x2F gives a two-byte message. `msgDone` pulses for one cycle after the final byte.
- R4: Any other first byte starts an extended message. Its length counts as 3 until the second byte arrives, and from then on it equals the value of that second byte.
- R5: When a message ends with bit 7 of its first byte set and bit 5 clear, bits 2:0 of that byte become the pending unit number (`msgLun`, with `msgLunValid` high). The next completed command carries it in bits 7:5 of byte 1, and `msgLunValid` then drops.
- R6: With no specific rule, the transfer length is byte 4 for a 6-byte descriptor and the big-endian value of bytes 7 and 8 otherwise.
- R7: Opcode 0x0A transfers byte 4 times 512 bytes, where a byte 4 of zero means 256. Opcode 0x2A transfers bytes 7 and 8 times 512 bytes.
- R8: Opcode 0x0F transfers 512 bytes, 0x0C transfers 8 bytes and 0x11 transfers 4 bytes.
- R9: Opcodes 0x06 and 0x07, and 0x04 with byte 1 bit 4 clear, have length 0 and direction none. Opcode 0x2F with byte 1 bit 1 set is outward with bytes 7 and 8 times 512 bytes; otherwise it has length 0 and direction none.
- R10: `xferDir` is 2'b00 for no data, 2'b01 for outward and 2'b10 for inward. Opcodes 0x04, 0x0A, 0x0C, 0x11, 0x2A, 0xAA, 0x15, 0x55 and 0x0F are outward. Read, inquiry, sense and similar codes are inward. All other codes are none. An outward result whose length is zero becomes none.
- R11: Any change of `phase` restarts both the command and the message byte counts, so the next byte taken is byte 0.
- R12: `cmdBytes`, `cmdLen`, `xferLen` and `xferDir` change only at a command completion, and they hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A bus byte is present this cycle |
| byteData | input | 8 | The byte |
| phase | input | 3 | Current bus phase code |
| cmdDone | output | 1 | One-cycle pulse: a descriptor is complete |
| cmdBytes | output | 128 | Completed descriptor, byte 0 in the low bits |
| cmdLen | output | 5 | Descriptor length in bytes |
| xferLen | output | XFER_W | Data phase length in bytes |
| xferDir | output | 2 | Data direction code |
| msgDone | output | 1 | One-cycle pulse: a message is complete |
| msgLunValid | output | 1 | A unit number is pending |
| msgLun | output | 3 | Pending unit number |

## Verification
On every cycle the assertions check that a completion pulse never lasts two cycles and that the reported length is one of the four legal values. They also check that the direction code is never the unused value, that an outward result always has a nonzero length, and that the results hold between completions. Only the bench's scenarios can show the arithmetic behind each opcode rule, the unit number landing in byte 1, the end points of single, two-byte and extended messages, and the count restart on a phase change, because each of these needs a known byte sequence to be compared against.

// File: rtl/scsi_collect_pkg.sv
package scsi_collect_pkg;

  localparam int CDB_MAX = 16;
  localparam int IDX_W   = $clog2(CDB_MAX + 1);

  localparam logic [2:0] PH_COMMAND = 3'd2;
  localparam logic [2:0] PH_MSG_OUT = 3'd6;

  localparam logic [1:0] DIR_NONE = 2'b00;
  localparam logic [1:0] DIR_OUT  = 2'b01;
  localparam logic [1:0] DIR_IN   = 2'b10;

  localparam logic [1:0] MK_ONE = 2'd0;
  localparam logic [1:0] MK_TWO = 2'd1;
  localparam logic [1:0] MK_EXT = 2'd2;

  typedef struct packed {
    logic             cmdWr;
    logic [IDX_W-1:0] cmdIdx;
    logic [IDX_W-1:0] cmdLen;
    logic             cmdFinish;
    logic             msgFinish;
    logic [7:0]       msgHead;
  } ctrlStrobe_t;

  function automatic logic [IDX_W-1:0] cdbLength(input logic [7:0] op);
    case (op[7:5])
      3'd0, 3'd7:       return IDX_W'(6);
      3'd1, 3'd2, 3'd6: return IDX_W'(10);
      3'd3, 3'd5:       return IDX_W'(12);
      default:          return IDX_W'(16);
    endcase
  endfunction

  function automatic logic [1:0] msgKind(input logic [7:0] h);
    if (h == 8'h00 || (h >= 8'h02 && h <= 8'h1F) || h[7]) return MK_ONE;
    else if (h[7:4] == 4'h2) return MK_TWO;
    else return MK_EXT;
  endfunction

  function automatic logic isOutward(input logic [7:0] op);
    case (op)
      8'h04, 8'h0A, 8'h0C, 8'h11, 8'h2A, 8'hAA, 8'h15, 8'h55, 8'h0F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic isInward(input logic [7:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h0E, 8'h12, 8'h1A, 8'h5A, 8'h25, 8'h28, 8'h34,
      8'h37, 8'h42, 8'h43, 8'hA8, 8'h51, 8'h52, 8'hB9, 8'hBD, 8'hD8, 8'hD9,
      8'hBE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/scsi_collect_ctrl.sv
module scsi_collect_ctrl
  import scsi_collect_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic [2:0]  phase,
  output ctrlStrobe_t strobe
);

  logic [2:0]       lastPhase;
  logic [IDX_W-1:0] cmdCnt;
  logic [7:0]       opcode;
  logic [7:0]       msgCnt;
  logic [7:0]       msgHead;
  logic [7:0]       msgSecond;

  logic             phaseMoved;
  logic [IDX_W-1:0] cmdPos;
  logic [7:0]       msgPos;
  logic             takeCmd;
  logic             takeMsg;

  assign phaseMoved = (phase != lastPhase);
  assign cmdPos     = phaseMoved ? '0 : cmdCnt;
  assign msgPos     = phaseMoved ? '0 : msgCnt;
  assign takeCmd    = byteValid && (phase == PH_COMMAND);
  assign takeMsg    = byteValid && (phase == PH_MSG_OUT);

  // command length from the opcode group (opcode may be in flight)
  logic [7:0]       curOp;
  logic [IDX_W-1:0] cmdNeed;
  logic [IDX_W-1:0] cmdNext;
  logic             cmdLast;

  assign curOp   = (cmdPos == '0) ? byteData : opcode;
  assign cmdNeed = cdbLength(curOp);
  assign cmdNext = cmdPos + IDX_W'(1);
  assign cmdLast = takeCmd && (cmdNext >= cmdNeed);

  // message length decoded as bytes arrive
  logic [7:0] curHead;
  logic [7:0] curSecond;
  logic [8:0] msgNext;
  logic [8:0] msgNeed;
  logic       msgLast;

  assign curHead   = (msgPos == 8'd0) ? byteData : msgHead;
  assign curSecond = (msgPos == 8'd1) ? byteData : msgSecond;
  assign msgNext   = {1'b0, msgPos} + 9'd1;

  always_comb begin
    case (msgKind(curHead))
      MK_ONE:  msgNeed = 9'd1;
      MK_TWO:  msgNeed = 9'd2;
      default: msgNeed = (msgNext < 9'd2) ? 9'd3 : {1'b0, curSecond};
    endcase
  end

  assign msgLast = takeMsg && (msgNext >= msgNeed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastPhase <= PH_COMMAND;
      cmdCnt    <= '0;
      opcode    <= '0;
      msgCnt    <= '0;
      msgHead   <= '0;
      msgSecond <= '0;
    end else begin
      lastPhase <= phase;
      if (phaseMoved) begin
        cmdCnt <= '0;
        msgCnt <= '0;
      end
      if (takeCmd) begin
        cmdCnt <= cmdLast ? '0 : cmdNext;
        if (cmdPos == '0) opcode <= byteData;
      end
      if (takeMsg) begin
        msgCnt <= msgLast ? 8'd0 : msgNext[7:0];
        if (msgPos == 8'd0) msgHead <= byteData;
        if (msgPos == 8'd1) msgSecond <= byteData;
      end
    end
  end

  always_comb begin
    strobe.cmdWr     = takeCmd;
    strobe.cmdIdx    = cmdPos;
    strobe.cmdLen    = cmdNeed;
    strobe.cmdFinish = cmdLast;
    strobe.msgFinish = msgLast;
    strobe.msgHead   = curHead;
  end

endmodule

// File: rtl/scsi_collect_dpath.sv
module scsi_collect_dpath
  import scsi_collect_pkg::*;
#(
  parameter int XFER_W      = 25,
  parameter int BLOCK_SHIFT = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             byteData,
  input  ctrlStrobe_t            strobe,
  output logic                   cmdDone,
  output logic [CDB_MAX*8-1:0]   cmdBytes,
  output logic [IDX_W-1:0]       cmdLen,
  output logic [XFER_W-1:0]      xferLen,
  output logic [1:0]             xferDir,
  output logic                   msgDone,
  output logic                   msgLunValid,
  output logic [2:0]             msgLun
);

  logic [7:0]           cdbBuf  [CDB_MAX];
  logic [7:0]           cdbView [CDB_MAX];
  logic [CDB_MAX*8-1:0] cdbFlat;
  logic                 lunPend;
  logic [2:0]           lunVal;

  for (genvar gi = 0; gi < CDB_MAX; gi++) begin : g_byte
    logic [7:0] v;
    always_comb begin
      v = (strobe.cmdWr && strobe.cmdIdx == IDX_W'(gi)) ? byteData : cdbBuf[gi];
      if (gi == 1 && lunPend) v = {lunVal, v[4:0]};
      if (IDX_W'(gi) >= strobe.cmdLen) v = '0;
    end
    assign cdbView[gi]          = v;
    assign cdbFlat[8*gi +: 8]   = v;

    always_ff @(posedge clk) begin
      if (!rst_n) cdbBuf[gi] <= '0;
      else if (strobe.cmdWr && strobe.cmdIdx == IDX_W'(gi)) cdbBuf[gi] <= byteData;
    end
  end

  // transfer length and direction rules
  logic [15:0]       count16;
  logic [XFER_W-1:0] lenC;
  logic [1:0]        dirC;
  logic              fixedDir;

  assign count16 = {cdbView[7], cdbView[8]};

  always_comb begin
    lenC     = (strobe.cmdLen == IDX_W'(6)) ? XFER_W'(cdbView[4]) : XFER_W'(count16);
    dirC     = DIR_NONE;
    fixedDir = 1'b0;
    case (cdbView[0])
      8'h04: if (!cdbView[1][4]) begin fixedDir = 1'b1; lenC = '0; end
      8'h06, 8'h07: begin fixedDir = 1'b1; lenC = '0; end
      8'h0C: lenC = XFER_W'(8);
      8'h11: lenC = XFER_W'(4);
      8'h0F: lenC = XFER_W'(1) << BLOCK_SHIFT;
      8'h0A: lenC = XFER_W'((cdbView[4] == 8'd0) ? 9'd256 : {1'b0, cdbView[4]}) << BLOCK_SHIFT;
      8'h2A: lenC = XFER_W'(count16) << BLOCK_SHIFT;
      8'h2F: begin
        fixedDir = 1'b1;
        if (cdbView[1][1]) begin
          lenC = XFER_W'(count16) << BLOCK_SHIFT;
          dirC = DIR_OUT;
        end else begin
          lenC = '0;
        end
      end
      default: ;
    endcase
    if (!fixedDir) begin
      if (isOutward(cdbView[0]))     dirC = DIR_OUT;
      else if (isInward(cdbView[0])) dirC = DIR_IN;
    end
    if (dirC == DIR_OUT && lenC == '0) dirC = DIR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdDone     <= 1'b0;
      msgDone     <= 1'b0;
      cmdBytes    <= '0;
      cmdLen      <= '0;
      xferLen     <= '0;
      xferDir     <= DIR_NONE;
      lunPend     <= 1'b0;
      lunVal      <= '0;
    end else begin
      cmdDone <= strobe.cmdFinish;
      msgDone <= strobe.msgFinish;
      if (strobe.cmdFinish) begin
        cmdBytes <= cdbFlat;
        cmdLen   <= strobe.cmdLen;
        xferLen  <= lenC;
        xferDir  <= dirC;
        lunPend  <= 1'b0;
      end
      if (strobe.msgFinish && strobe.msgHead[7] && !strobe.msgHead[5]) begin
        lunPend <= 1'b1;
        lunVal  <= strobe.msgHead[2:0];
      end
    end
  end

  assign msgLunValid = lunPend;
  assign msgLun      = lunVal;

endmodule

// File: rtl/scsi_collect.sv
module scsi_collect
  import scsi_collect_pkg::*;
#(
  parameter int XFER_W      = 25,
  parameter int BLOCK_SHIFT = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byteValid,
  input  logic [7:0]           byteData,
  input  logic [2:0]           phase,
  output logic                 cmdDone,
  output logic [CDB_MAX*8-1:0] cmdBytes,
  output logic [IDX_W-1:0]     cmdLen,
  output logic [XFER_W-1:0]    xferLen,
  output logic [1:0]           xferDir,
  output logic                 msgDone,
  output logic                 msgLunValid,
  output logic [2:0]           msgLun
);

  ctrlStrobe_t strobe;

  scsi_collect_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .byteValid (byteValid),
    .byteData  (byteData),
    .phase     (phase),
    .strobe    (strobe)
  );

  scsi_collect_dpath #(
    .XFER_W      (XFER_W),
    .BLOCK_SHIFT (BLOCK_SHIFT)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .byteData    (byteData),
    .strobe      (strobe),
    .cmdDone     (cmdDone),
    .cmdBytes    (cmdBytes),
    .cmdLen      (cmdLen),
    .xferLen     (xferLen),
    .xferDir     (xferDir),
    .msgDone     (msgDone),
    .msgLunValid (msgLunValid),
    .msgLun      (msgLun)
  );

endmodule

// File: rtl/scsi_collect_chk.sv
module scsi_collect_chk
  import scsi_collect_pkg::*;
#(
  parameter int XFER_W = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdDone,
  input logic [IDX_W-1:0]  cmdLen,
  input logic [XFER_W-1:0] xferLen,
  input logic [1:0]        xferDir
);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmdDone |=> !cmdDone);

  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmdDone |-> (cmdLen == 5'd6 || cmdLen == 5'd10 || cmdLen == 5'd12 || cmdLen == 5'd16));

  a_r10_dir_legal: assert property (@(posedge clk) disable iff (!rst_n)
    xferDir != 2'b11);

  a_r10_out_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdDone && xferDir == DIR_OUT) |-> (xferLen != '0));

  a_r12_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdDone |-> $stable(xferLen));

  a_r12_hold_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdDone |-> ($stable(xferDir) && $stable(cmdLen)));

endmodule

bind scsi_collect scsi_collect_chk #(.XFER_W(XFER_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmdDone (cmdDone),
  .cmdLen  (cmdLen),
  .xferLen (xferLen),
  .xferDir (xferDir)
);

// File: tb/scsi_collect_test.sv
module scsi_collect_test;

  localparam logic [2:0] PH_CMD = 3'd2;
  localparam logic [2:0] PH_MSG = 3'd6;
  localparam logic [1:0] D_NONE = 2'b00;
  localparam logic [1:0] D_OUT  = 2'b01;
  localparam logic [1:0] D_IN   = 2'b10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         byteValid = 1'b0;
  logic [7:0]   byteData = 8'h00;
  logic [2:0]   phase = 3'd7;
  logic         cmdDone;
  logic [127:0] cmdBytes;
  logic [4:0]   cmdLen;
  logic [24:0]  xferLen;
  logic [1:0]   xferDir;
  logic         msgDone;
  logic         msgLunValid;
  logic [2:0]   msgLun;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  scsi_collect uut (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteData(byteData),
    .phase(phase), .cmdDone(cmdDone), .cmdBytes(cmdBytes), .cmdLen(cmdLen),
    .xferLen(xferLen), .xferDir(xferDir), .msgDone(msgDone),
    .msgLunValid(msgLunValid), .msgLun(msgLun)
  );

  // scoreboard queues
  string        qTag [$];
  logic [127:0] qVec [$];
  int           qCl  [$];
  logic [24:0]  qLen [$];
  logic [1:0]   qDir [$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (qTag.size() != 0) chk(0, "R2 completions missing", 128'(qTag.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // monitor: compare each completion with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && cmdDone) begin
      if (qTag.size() == 0) chk(0, "R2 unexpected completion", 1, 0);
      else begin
        string t;
        logic [127:0] v;
        int cl;
        logic [24:0] ln;
        logic [1:0] dr;
        t = qTag.pop_front(); v = qVec.pop_front(); cl = qCl.pop_front();
        ln = qLen.pop_front(); dr = qDir.pop_front();
        chk(cmdBytes == v, {t, " bytes (R2)"}, cmdBytes, v);
        chk(int'(cmdLen) == cl, {t, " cmdLen (R2)"}, 128'(cmdLen), 128'(cl));
        chk(xferLen == ln, {t, " xferLen"}, 128'(xferLen), 128'(ln));
        chk(xferDir == dr, {t, " xferDir (R10)"}, 128'(xferDir), 128'(dr));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finishRun();
  end

  task automatic sendByte(input logic [2:0] ph, input logic [7:0] b);
    @(negedge clk);
    phase = ph; byteValid = 1'b1; byteData = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  function automatic logic [127:0] mkCdb(input logic [7:0] b0, b1, b4, b7, b8);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = 8'hA0 + 8'(i);
    v[7:0] = b0; v[15:8] = b1; v[39:32] = b4; v[63:56] = b7; v[71:64] = b8;
    return v;
  endfunction

  task automatic sendCmd(input string tag, input logic [127:0] c, input int n,
                         input logic [24:0] expLen, input logic [1:0] expDir,
                         input bit useLun, input logic [2:0] lun);
    logic [127:0] e;
    e = '0;
    for (int i = 0; i < n; i++) e[8*i +: 8] = c[8*i +: 8];
    if (useLun) e[15:13] = lun;
    qTag.push_back(tag); qVec.push_back(e); qCl.push_back(n);
    qLen.push_back(expLen); qDir.push_back(expDir);
    for (int i = 0; i < n; i++) sendByte(PH_CMD, c[8*i +: 8]);
  endtask

  // message: msgDone must appear only after the last byte
  task automatic sendMsg(input string tag, input logic [63:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      sendByte(PH_MSG, m[8*i +: 8]);
      chk(msgDone == (i == n - 1), {tag, " msgDone"}, 128'(msgDone), 128'(i == n - 1));
    end
  endtask

  initial begin
    logic [127:0] savedBytes;
    logic [24:0]  savedLen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmdDone && !msgDone, "reset done pulses", {cmdDone, msgDone}, 0);
    chk(xferLen == 0 && xferDir == D_NONE && cmdBytes == 0, "reset results", 128'(xferLen), 0);
    chk(!msgLunValid, "reset R5 lun", 128'(msgLunValid), 0);

    // R6 defaults and R10 direction classes
    sendCmd("R6 none-class 6B", mkCdb(8'h00, 8'h00, 8'h12, 8'h00, 8'h00), 6, 25'h12, D_NONE, 0, 0);
    sendCmd("R6 read6", mkCdb(8'h08, 8'h00, 8'h20, 8'h00, 8'h00), 6, 25'h20, D_IN, 0, 0);
    sendCmd("R6 read10", mkCdb(8'h28, 8'h00, 8'h00, 8'h01, 8'h02), 10, 25'h102, D_IN, 0, 0);
    sendCmd("R10 inquiry", mkCdb(8'h12, 8'h00, 8'h24, 8'h00, 8'h00), 6, 25'h24, D_IN, 0, 0);
    sendCmd("R10 out 0x15", mkCdb(8'h15, 8'h00, 8'h0C, 8'h00, 8'h00), 6, 25'h0C, D_OUT, 0, 0);

    // R7 block-scaled writes
    sendCmd("R7 write6 zero=256", mkCdb(8'h0A, 8'h00, 8'h00, 8'h00, 8'h00), 6, 25'h20000, D_OUT, 0, 0);
    sendCmd("R7 write6 3", mkCdb(8'h0A, 8'h00, 8'h03, 8'h00, 8'h00), 6, 25'h600, D_OUT, 0, 0);
    sendCmd("R7 write10 max", mkCdb(8'h2A, 8'h00, 8'h00, 8'hFF, 8'hFF), 10, 25'h1FFFE00, D_OUT, 0, 0);
    sendCmd("R10 write10 zero->none", mkCdb(8'h2A, 8'h00, 8'h00, 8'h00, 8'h00), 10, 25'h0, D_NONE, 0, 0);

    // R8 fixed lengths
    sendCmd("R8 sector buffer", mkCdb(8'h0F, 8'h00, 8'h00, 8'h00, 8'h00), 6, 25'd512, D_OUT, 0, 0);
    sendCmd("R8 drive chars", mkCdb(8'h0C, 8'h00, 8'h77, 8'h00, 8'h00), 6, 25'd8, D_OUT, 0, 0);
    sendCmd("R8 alt track", mkCdb(8'h11, 8'h00, 8'h77, 8'h00, 8'h00), 6, 25'd4, D_OUT, 0, 0);

    // R9 no-data rules
    sendCmd("R9 format no flag", mkCdb(8'h04, 8'h00, 8'h07, 8'h00, 8'h00), 6, 25'd0, D_NONE, 0, 0);
    sendCmd("R9 format with flag", mkCdb(8'h04, 8'h10, 8'h07, 8'h00, 8'h00), 6, 25'd7, D_OUT, 0, 0);
    sendCmd("R9 format track", mkCdb(8'h06, 8'h00, 8'h55, 8'h00, 8'h00), 6, 25'd0, D_NONE, 0, 0);
    sendCmd("R9 verify bytchk", mkCdb(8'h2F, 8'h02, 8'h00, 8'h00, 8'h02), 10, 25'h400, D_OUT, 0, 0);
    sendCmd("R9 verify plain", mkCdb(8'h2F, 8'h00, 8'h00, 8'h00, 8'h02), 10, 25'd0, D_NONE, 0, 0);

    // R2 every length group
    sendCmd("R2 group5 read12", mkCdb(8'hA8, 8'h00, 8'h00, 8'h00, 8'h10), 12, 25'h10, D_IN, 0, 0);
    sendCmd("R2 group4", mkCdb(8'h88, 8'h00, 8'h00, 8'h01, 8'h00), 16, 25'h100, D_NONE, 0, 0);
    sendCmd("R2 group3", mkCdb(8'h60, 8'h00, 8'h00, 8'h00, 8'h05), 12, 25'h5, D_NONE, 0, 0);
    sendCmd("R2 group6", mkCdb(8'hC0, 8'h00, 8'h00, 8'h00, 8'h09), 10, 25'h9, D_NONE, 0, 0);
    sendCmd("R2 group7", mkCdb(8'hE0, 8'h00, 8'h33, 8'h00, 8'h00), 6, 25'h33, D_NONE, 0, 0);

    // R3 / R4 message boundaries
    sendMsg("R3 single 0x00", 64'h00, 1);
    sendMsg("R3 single 0x1F", 64'h1F, 1);
    sendMsg("R3 two-byte", 64'h1123, 2);
    sendMsg("R4 extended 5", 64'hCCBBAA0501, 5);
    sendMsg("R4 extended 2", 64'h0201, 2);
    chk(!msgLunValid, "R5 no identify yet", 128'(msgLunValid), 0);

    // R5 identify unit number
    sendMsg("R5 not identify 0xA0", 64'hA0, 1);
    chk(!msgLunValid, "R5 bit5 set ignored", 128'(msgLunValid), 0);
    sendMsg("R5 identify 0xC3", 64'hC3, 1);
    chk(msgLunValid && msgLun == 3'd3, "R5 lun latched", {msgLunValid, msgLun}, {1'b1, 3'd3});
    sendCmd("R5 lun into byte1", mkCdb(8'h08, 8'h1F, 8'h04, 8'h00, 8'h00), 6, 25'h4, D_IN, 1, 3'd3);
    chk(!msgLunValid, "R5 lun consumed", 128'(msgLunValid), 0);
    sendCmd("R5 byte1 untouched", mkCdb(8'h08, 8'h1F, 8'h04, 8'h00, 8'h00), 6, 25'h4, D_IN, 0, 0);

    // R1 other phases ignored, R12 hold
    savedBytes = cmdBytes; savedLen = xferLen;
    for (int i = 0; i < 6; i++) begin
      sendByte(3'd0, 8'h0A);
      chk(!cmdDone && !msgDone, "R1 data-out byte ignored", {cmdDone, msgDone}, 0);
    end
    for (int i = 0; i < 3; i++) sendByte(3'd3, 8'h80);
    chk(!msgLunValid, "R1 status phase byte ignored", 128'(msgLunValid), 0);
    repeat (5) @(negedge clk);
    chk(cmdBytes == savedBytes, "R12 bytes held", cmdBytes, savedBytes);
    chk(xferLen == savedLen, "R12 length held", 128'(xferLen), 128'(savedLen));

    // R11 phase change restarts counting
    sendByte(PH_CMD, 8'h28);
    sendByte(PH_CMD, 8'h00);
    sendByte(PH_CMD, 8'h00);
    sendMsg("R11 identify mid-command", 64'h80, 1);
    chk(msgLunValid && msgLun == 3'd0, "R11 lun 0 pending", {msgLunValid, msgLun}, {1'b1, 3'd0});
    sendCmd("R11 restarted command", mkCdb(8'h08, 8'hE5, 8'h02, 8'h00, 8'h00), 6, 25'h2, D_IN, 1, 3'd0);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule